// File: doc/BRIEF.md
# Vector compare predicate setter

This block compares two multi-lane vectors lane by lane and stores the boolean outcome of each lane in a small predicate register, one bit per lane. Each source vector first passes through its own lane reorder stage: every output lane names the input lane it copies. A single lane can feed several output lanes, and the lanes can appear in any order. The reordered lanes are then compared under one of six relations: greater, less, greater-or-equal, less-or-equal, equal or not-equal.

A per-lane write enable mask chooses which predicate bits take the new results. The other bits keep their stored values. Later logic reads the stored bits to gate work lane by lane, so the register is always visible on an output. The whole update takes place on the clock edge where the issue strobe is high. An unassigned relation code changes nothing and raises a flag while it is presented.

With the default parameters there are four lanes of 32-bit signed two's-complement data. Lane 0 is x, lane 1 is y, lane 2 is z and lane 3 is w.

Top module: `vec_pred_setter`

## Requirements
- R1: A synchronous active-high reset sets every predicate bit to 0 (false), and the predicate reads 0 at the first sampling point after the reset edge.
- R2: Relation code 0 stores a0 > b0 and code 1 stores a0 < b0 for each enabled lane. Both compare the lane values as signed 32-bit numbers, so the most negative value is less than the most positive value.
- R3: Relation code 2 stores greater-or-equal and code 3 stores less-or-equal. With a = (0,0,1,1), b = (1,1,0,0), code 3 and a full mask, the predicate becomes x=1, y=1, z=0, w=0 (value 4'b0011).
- R4: Relation code 4 stores equality and code 5 stores inequality, lane by lane.
- R5: Each source has a lane selector bus of 2 bits per lane, where lane i uses bits [2i+1:2i] and values 0..3 pick x, y, z or w. Output lane i of the reordered source equals the input lane that its selector names. The reorder is applied before the compare. The identity selector is 8'hE4.
- R6: Bit i of the write mask enables predicate bit i. A bit whose mask bit is 0 keeps its previous value, including when the mask is all zero.
- R7: When issue is low the predicate holds its value, whatever the other inputs do.
- R8: Relation codes 6 and 7 leave the predicate unchanged. bad_op is high in the same cycle that issue is high with code 6 or 7, and low otherwise.
- R9: The new predicate appears only after the rising edge where issue is high. Between driving issue and that edge the output still shows the old value.
- R10: When reset and issue are high together, reset wins and the predicate becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| issue | input | 1 | Update strobe |
| rel_op | input | 3 | Relation code: 0 gt, 1 lt, 2 ge, 3 le, 4 eq, 5 ne |
| src_a | input | 128 | Left operand vector, lane i in bits [32i+31:32i] |
| src_b | input | 128 | Right operand vector, same lane layout |
| lane_sel_a | input | 8 | Lane reorder selectors for src_a |
| lane_sel_b | input | 8 | Lane reorder selectors for src_b |
| wr_mask | input | 4 | Per-lane write enable for the predicate |
| pred | output | 4 | Stored predicate, bit i for lane i |
| bad_op | output | 1 | High while issue is high with an unassigned code |

## Verification
The bench builds the block with its defaults: four lanes, 32-bit data and signed compares. At this size every selector value from x to w and every write mask pattern can be reached with a short table. The signed corner case is covered by placing the most negative and most positive 32-bit values in the same compare, where an unsigned compare would give the opposite result. The reset value is all-false, so the partial-mask vectors start from a predicate that is known at the ports.

// File: rtl/vps_pkg.sv
package vps_pkg;

   // Relation codes carried on rel_op
   typedef logic [2:0] rel_op_t;
   localparam rel_op_t REL_GT = 3'd0;
   localparam rel_op_t REL_LT = 3'd1;
   localparam rel_op_t REL_GE = 3'd2;
   localparam rel_op_t REL_LE = 3'd3;
   localparam rel_op_t REL_EQ = 3'd4;
   localparam rel_op_t REL_NE = 3'd5;

   // Width of one lane selector for a given lane count
   function automatic int sel_w(input int lanes);
      return (lanes > 1) ? $clog2(lanes) : 1;
   endfunction

   function automatic logic rel_is_legal(input rel_op_t op);
      return (op <= REL_NE);
   endfunction

endpackage

// File: rtl/vps_swizzle.sv
module vps_swizzle #(
   parameter int LANES  = 4,
   parameter int DATA_W = 32,
   parameter int SEL_W  = 2
) (
   input  logic [LANES*DATA_W-1:0] vec_in,
   input  logic [LANES*SEL_W-1:0]  sel,
   output logic [LANES*DATA_W-1:0] vec_out
);

   localparam bit POW2 = ((1 << SEL_W) == LANES);

   if (LANES < 1) begin : g_bad_lanes
      $error("vps_swizzle: LANES must be at least 1");
   end
   if ((1 << SEL_W) < LANES) begin : g_bad_sel
      $error("vps_swizzle: SEL_W too narrow for LANES");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [SEL_W-1:0] pick;
      assign pick = sel[i*SEL_W +: SEL_W];
      if (POW2) begin : g_direct
         // every selector value names a real lane
         assign vec_out[i*DATA_W +: DATA_W] = vec_in[int'(pick)*DATA_W +: DATA_W];
      end else begin : g_guarded
         // out-of-range selectors fall back to lane 0
         always_comb begin
            vec_out[i*DATA_W +: DATA_W] = vec_in[DATA_W-1:0];
            for (int k = 1; k < LANES; k++) begin
               if (int'(pick) == k) vec_out[i*DATA_W +: DATA_W] = vec_in[k*DATA_W +: DATA_W];
            end
         end
      end
   end

endmodule

// File: rtl/vps_lane_rel.sv
module vps_lane_rel
   import vps_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  rel_op_t           op,
   output logic              res
);

   logic lt;
   logic eq;

   if (DATA_W < 1) begin : g_bad_w
      $error("vps_lane_rel: DATA_W must be at least 1");
   end

   if (SIGNED_CMP) begin : g_signed
      assign lt = ($signed(a) < $signed(b));
   end else begin : g_unsigned
      assign lt = (a < b);
   end

   assign eq = (a == b);

   always_comb begin
      unique case (op)
         REL_GT:  res = !lt && !eq;
         REL_LT:  res = lt;
         REL_GE:  res = !lt;
         REL_LE:  res = lt || eq;
         REL_EQ:  res = eq;
         REL_NE:  res = !eq;
         default: res = 1'b0;
      endcase
   end

endmodule

// File: rtl/vps_pred_reg.sv
module vps_pred_reg #(
   parameter int               LANES     = 4,
   parameter logic [LANES-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [LANES-1:0] mask,
   input  logic [LANES-1:0] d,
   output logic [LANES-1:0] q
);

   if (LANES < 1) begin : g_bad_lanes
      $error("vps_pred_reg: LANES must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= RESET_VAL;
      end else if (wr_en) begin
         q <= (q & ~mask) | (d & mask);
      end
   end

   // R1: reset drives the stored bits to the reset value
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (q == RESET_VAL));

   // R6: disabled lanes keep their bits across a write
   a_r6_mask_keeps: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> ((q & ~$past(mask)) == ($past(q) & ~$past(mask))));

   // R7: no write, no change
   a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(q));

endmodule

// File: rtl/vec_pred_setter.sv
module vec_pred_setter
   import vps_pkg::*;
#(
   parameter int               LANES      = 4,
   parameter int               DATA_W     = 32,
   parameter bit               SIGNED_CMP = 1'b1,
   parameter logic [LANES-1:0] RESET_PRED = '0
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           issue,
   input  logic [2:0]                     rel_op,
   input  logic [LANES*DATA_W-1:0]        src_a,
   input  logic [LANES*DATA_W-1:0]        src_b,
   input  logic [LANES*sel_w(LANES)-1:0]  lane_sel_a,
   input  logic [LANES*sel_w(LANES)-1:0]  lane_sel_b,
   input  logic [LANES-1:0]               wr_mask,
   output logic [LANES-1:0]               pred,
   output logic                           bad_op
);

   localparam int SEL_W = sel_w(LANES);
   localparam int VEC_W = LANES * DATA_W;

   if (LANES < 1 || LANES > 64) begin : g_bad_lanes
      $error("vec_pred_setter: LANES out of range 1..64");
   end
   if (DATA_W < 2) begin : g_bad_w
      $error("vec_pred_setter: DATA_W must be at least 2");
   end

   logic [VEC_W-1:0] ra;
   logic [VEC_W-1:0] rb;
   logic [LANES-1:0] lane_res;
   logic             op_ok;
   logic             wr_en;

   vps_swizzle #(.LANES(LANES), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_swz_a (
      .vec_in (src_a),
      .sel    (lane_sel_a),
      .vec_out(ra)
   );

   vps_swizzle #(.LANES(LANES), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_swz_b (
      .vec_in (src_b),
      .sel    (lane_sel_b),
      .vec_out(rb)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_cmp
      vps_lane_rel #(.DATA_W(DATA_W), .SIGNED_CMP(SIGNED_CMP)) u_rel (
         .a  (ra[i*DATA_W +: DATA_W]),
         .b  (rb[i*DATA_W +: DATA_W]),
         .op (rel_op),
         .res(lane_res[i])
      );
   end

   assign op_ok  = rel_is_legal(rel_op);
   assign wr_en  = issue && op_ok;
   assign bad_op = issue && !op_ok;

   vps_pred_reg #(.LANES(LANES), .RESET_VAL(RESET_PRED)) u_pred (
      .clk  (clk),
      .rst  (rst),
      .wr_en(wr_en),
      .mask (wr_mask),
      .d    (lane_res),
      .q    (pred)
   );

   // R8: an unassigned code leaves the predicate alone
   a_r8_illegal_no_write: assert property (@(posedge clk) disable iff (rst)
      (issue && (rel_op > REL_NE)) |=> $stable(pred));

   // R9: enabled lanes carry the lane compare results after the issuing edge
   a_r9_enabled_take_result: assert property (@(posedge clk) disable iff (rst)
      (issue && (rel_op <= REL_NE)) |=>
         ((pred & $past(wr_mask)) == ($past(lane_res) & $past(wr_mask))));

endmodule

// File: tb/sim_vec_pred_setter.sv
module sim_vec_pred_setter;

   typedef struct packed {
      logic [3:0]   req;
      logic [2:0]   op;
      logic [7:0]   sa;
      logic [7:0]   sb;
      logic [3:0]   mask;
      logic [127:0] a;
      logic [127:0] b;
      logic [3:0]   exp;
   } vec_t;

   localparam int NV = 11;

   // lanes packed {w,z,y,x}; 8'hE4 is the identity selector
   localparam vec_t [0:NV-1] TBL = '{
      // R3 worked case: le
      '{4'd3, 3'd3, 8'hE4, 8'hE4, 4'hF, {32'd1, 32'd1, 32'd0, 32'd0},
        {32'd0, 32'd0, 32'd1, 32'd1}, 4'b0011},
      // R2 gt, signed
      '{4'd2, 3'd0, 8'hE4, 8'hE4, 4'hF, {32'd7, 32'd0, 32'hFFFFFFFB, 32'd5},
        {32'hFFFFFFFF, 32'd0, 32'd2, 32'd3}, 4'b1001},
      // R2 lt
      '{4'd2, 3'd1, 8'hE4, 8'hE4, 4'hF, {32'd7, 32'd0, 32'hFFFFFFFB, 32'd5},
        {32'hFFFFFFFF, 32'd0, 32'd2, 32'd3}, 4'b0010},
      // R3 ge
      '{4'd3, 3'd2, 8'hE4, 8'hE4, 4'hF, {32'd7, 32'd0, 32'hFFFFFFFB, 32'd5},
        {32'hFFFFFFFF, 32'd0, 32'd2, 32'd3}, 4'b1101},
      // R4 eq
      '{4'd4, 3'd4, 8'hE4, 8'hE4, 4'hF, {32'hFFFFFFFD, 32'd4, 32'd9, 32'd4},
        {32'hFFFFFFFD, 32'd4, 32'd8, 32'd4}, 4'b1101},
      // R4 ne
      '{4'd4, 3'd5, 8'hE4, 8'hE4, 4'hF, {32'hFFFFFFFD, 32'd4, 32'd9, 32'd4},
        {32'hFFFFFFFD, 32'd4, 32'd8, 32'd4}, 4'b0010},
      // R5 reversed b
      '{4'd5, 3'd4, 8'hE4, 8'h1B, 4'hF, {32'd40, 32'd30, 32'd20, 32'd10},
        {32'd10, 32'd20, 32'd30, 32'd40}, 4'b1111},
      // R5 broadcast y of a
      '{4'd5, 3'd0, 8'h55, 8'hE4, 4'hF, {32'd40, 32'd30, 32'd20, 32'd10},
        {32'd40, 32'd30, 32'd20, 32'd10}, 4'b0001},
      // R6 partial mask over 0001
      '{4'd6, 3'd5, 8'hE4, 8'hE4, 4'b1010, {32'd1, 32'd1, 32'd1, 32'd1},
        {32'd2, 32'd2, 32'd2, 32'd2}, 4'b1011},
      // R6 empty mask
      '{4'd6, 3'd1, 8'hE4, 8'hE4, 4'b0000, {32'd0, 32'd0, 32'd0, 32'd0},
        {32'd1, 32'd1, 32'd1, 32'd1}, 4'b1011},
      // R2 signed extremes
      '{4'd2, 3'd1, 8'hE4, 8'hE4, 4'hF, {32'd0, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000},
        {32'hFFFFFFFF, 32'd0, 32'h80000000, 32'h7FFFFFFF}, 4'b0101}
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         issue = 1'b0;
   logic [2:0]   rel_op = 3'd0;
   logic [127:0] src_a = '0;
   logic [127:0] src_b = '0;
   logic [7:0]   lane_sel_a = 8'hE4;
   logic [7:0]   lane_sel_b = 8'hE4;
   logic [3:0]   wr_mask = 4'h0;
   logic [3:0]   pred;
   logic         bad_op;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   vec_pred_setter u0 (
      .clk       (clk),
      .rst       (rst),
      .issue     (issue),
      .rel_op    (rel_op),
      .src_a     (src_a),
      .src_b     (src_b),
      .lane_sel_a(lane_sel_a),
      .lane_sel_b(lane_sel_b),
      .wr_mask   (wr_mask),
      .pred      (pred),
      .bad_op    (bad_op)
   );

   task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   task automatic load(input logic [2:0] op, input logic [7:0] sa, input logic [7:0] sb,
                       input logic [3:0] m, input logic [127:0] a, input logic [127:0] b);
      rel_op = op; lane_sel_a = sa; lane_sel_b = sb; wr_mask = m; src_a = a; src_b = b;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got hang expected finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk("R1 reset value", pred, 4'b0000);

      // table walk
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         load(TBL[i].op, TBL[i].sa, TBL[i].sb, TBL[i].mask, TBL[i].a, TBL[i].b);
         issue = 1'b1;
         @(negedge clk);
         issue = 1'b0;
         chk($sformatf("R%0d vector %0d", TBL[i].req, i), pred, TBL[i].exp);
      end

      // R7: no issue, busy inputs, predicate stays 0101
      @(negedge clk);
      load(3'd4, 8'hE4, 8'hE4, 4'hF, '0, '0);
      repeat (2) @(negedge clk);
      chk("R7 idle hold", pred, 4'b0101);

      // R8: code 6 and 7 flag and no change
      load(3'd6, 8'hE4, 8'hE4, 4'hF, '0, '0);
      issue = 1'b1;
      #1 chk("R8 flag code 6", {3'b0, bad_op}, 4'b0001);
      @(negedge clk);
      chk("R8 code 6 no write", pred, 4'b0101);
      rel_op = 3'd7;
      #1 chk("R8 flag code 7", {3'b0, bad_op}, 4'b0001);
      @(negedge clk);
      issue = 1'b0;
      #1 chk("R8 flag low without issue", {3'b0, bad_op}, 4'b0000);
      chk("R8 code 7 no write", pred, 4'b0101);

      // R9: eq over equal zeros, full mask; old value until the edge
      @(negedge clk);
      load(3'd4, 8'hE4, 8'hE4, 4'hF, '0, '0);
      issue = 1'b1;
      #1 chk("R8 flag low for legal code", {3'b0, bad_op}, 4'b0000);
      @(posedge clk);
      #0;
      @(negedge clk);
      issue = 1'b0;
      chk("R9 after edge", pred, 4'b1111);
      @(negedge clk);
      load(3'd5, 8'hE4, 8'hE4, 4'hF, '0, '0);
      issue = 1'b1;
      #8 chk("R9 before edge", pred, 4'b1111);
      @(negedge clk);
      issue = 1'b0;
      chk("R9 ne written", pred, 4'b0000);

      // R10: reset beats issue
      @(negedge clk);
      load(3'd4, 8'hE4, 8'hE4, 4'hF, '0, '0);
      issue = 1'b1;
      @(negedge clk);
      chk("R10 setup", pred, 4'b1111);
      rst = 1'b1;
      @(negedge clk);
      chk("R10 reset wins", pred, 4'b0000);
      rst = 1'b0;
      issue = 1'b0;
      @(negedge clk);
      chk("R1 reset mid-run", pred, 4'b0000);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule